// File: doc/BRIEF.md
# Segmented ROM/RAM Bank Mapper

This block sits on the cartridge side of an 8-bit processor bus and maps a 4 KB cartridge window onto a larger external ROM and a separate external RAM. The window holds four 1 KB ROM slots. It also holds four 512-byte RAM slots that overlap the lower half of the window for reads. Each RAM slot also has a write alias 0x800 higher. Each slot can be pointed at any bank on its own.

Software changes the mapping by writing one byte to one of two low-page addresses. One address loads ROM slots and the other loads RAM slots. The top two bits of the byte choose which slot changes. The low bits choose the bank. The mapper only watches these writes. The low-page peripheral still takes the bus cycle.

For every window access, the block turns the CPU address into a physical ROM or RAM address and raises the matching enables. It also selects the byte that goes back to the CPU. A mapped RAM slot has priority over the ROM slot that shares its address range.

Top module: `seg_bank_mapper`

## Requirements
- R1: After reset, only ROM slot 3 (offsets 0xC00–0xFFF) is mapped, and it holds ROM bank 0. A read at any other window offset returns 0xFF.
- R2: A write with address bit 12 low and bits 11:0 equal to 0x03F loads ROM slot data[7:6] with ROM bank data[5:0]. Reads in the next cycle use the new mapping.
- R3: A write with address bit 12 low and bits 11:0 equal to 0x03E loads RAM slot data[7:6] with RAM bank data[5:0] modulo 32 (data bit 5 is dropped).
- R4: Writes to any other address leave the mapping unchanged. This includes other low-page addresses and window addresses whose low bits match a hotspot.
- R5: A read at window offset o < 0x800 whose RAM slot o[10:9] is mapped raises ram_re. The RAM address is bank×512 + o[8:0].
- R6: A write at window offset o ≥ 0x800 whose RAM slot o[10:9] is mapped raises ram_we, with the RAM address bank×512 + o[8:0]. Every other write in the window leaves ram_we low.
- R7: A mapped RAM slot hides only the 512-byte halves of ROM that share its read and write ranges. The other half of each such ROM slot still reads from ROM.
- R8: A read at an offset covered by no readable slot returns 0xFF with rom_re and ram_re low. The RAM write alias is one such offset.
- R9: A mapped ROM read raises rom_re, drives rom_addr = bank×1024 + o[9:0], and returns rom_rdata. A RAM read returns ram_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 13 | CPU address; bit 12 selects the cartridge window |
| bus_re | input | 1 | Read cycle qualifier |
| bus_we | input | 1 | Write cycle qualifier |
| bus_wdata | input | 8 | CPU write data |
| rom_rdata | input | 8 | Byte from the external ROM |
| ram_rdata | input | 8 | Byte from the external RAM |
| rom_addr | output | 16 | Physical ROM byte address |
| rom_re | output | 1 | ROM read enable |
| ram_addr | output | 14 | Physical RAM byte address |
| ram_re | output | 1 | RAM read enable |
| ram_we | output | 1 | RAM write enable |
| cart_rdata | output | 8 | Byte returned to the CPU |

## Verification
Two functions can apply to the same access. A RAM slot's ranges overlap two ROM slots, so a ROM mapping and a RAM mapping both cover some offsets. In those cycles the priority logic must choose exactly one source. The bench maps ROM slots first and then adds RAM slots on top of them. It then sweeps every window offset for reads and for writes. At each offset it predicts, from the slot arithmetic alone, whether ROM, RAM or nothing should answer, and compares the enables, the physical address and the returned byte.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  localparam int SLOTS      = 4;
  localparam int SLOT_W     = 2;
  localparam int ROM_OFF_W  = 10;
  localparam int RAM_OFF_W  = 9;
  localparam int WIN_W      = 12;
  localparam int BYTE_W     = 8;
  localparam logic [WIN_W-1:0] HS_RAM = 12'h03E;
  localparam logic [WIN_W-1:0] HS_ROM = 12'h03F;
endpackage

// File: rtl/sbm_hotspot.sv
module sbm_hotspot
  import sbm_pkg::*;
(
  input  logic [WIN_W:0] bus_addr,
  input  logic           bus_we,
  output logic           rom_hit,
  output logic           ram_hit
);
  logic low_page_wr;

  always_comb begin
    low_page_wr = bus_we && !bus_addr[WIN_W];
    rom_hit     = low_page_wr && (bus_addr[WIN_W-1:0] == HS_ROM);
    ram_hit     = low_page_wr && (bus_addr[WIN_W-1:0] == HS_RAM);
  end
endmodule

// File: rtl/sbm_map_regs.sv
module sbm_map_regs
  import sbm_pkg::*;
#(
  parameter int ROM_BANK_W = 6,
  parameter int RAM_BANK_W = 5
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              rom_hit,
  input  logic                              ram_hit,
  input  logic [BYTE_W-1:0]                 wdata,
  output logic [SLOTS-1:0]                  rom_valid,
  output logic [SLOTS-1:0][ROM_BANK_W-1:0]  rom_bank,
  output logic [SLOTS-1:0]                  ram_valid,
  output logic [SLOTS-1:0][RAM_BANK_W-1:0]  ram_bank
);
  logic [SLOTS-1:0]                 rv_d, rv_q, av_d, av_q;
  logic [SLOTS-1:0][ROM_BANK_W-1:0] rb_d, rb_q;
  logic [SLOTS-1:0][RAM_BANK_W-1:0] ab_d, ab_q;
  logic                             upd_en;
  logic [SLOT_W-1:0]                dest;

  assign dest   = wdata[BYTE_W-1 -: SLOT_W];
  assign upd_en = rom_hit || ram_hit;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_comb begin
      rv_d[g] = rv_q[g];
      rb_d[g] = rb_q[g];
      av_d[g] = av_q[g];
      ab_d[g] = ab_q[g];
      if (rom_hit && dest == SLOT_W'(g)) begin
        rv_d[g] = 1'b1;
        rb_d[g] = wdata[ROM_BANK_W-1:0];
      end
      if (ram_hit && dest == SLOT_W'(g)) begin
        av_d[g] = 1'b1;
        ab_d[g] = wdata[RAM_BANK_W-1:0];
      end
    end

    p_rom_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rom_hit && dest == SLOT_W'(g)) |=>
        (rom_valid[g] && rom_bank[g] == $past(wdata[ROM_BANK_W-1:0])));

    p_ram_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_hit && dest == SLOT_W'(g)) |=>
        (ram_valid[g] && ram_bank[g] == $past(wdata[RAM_BANK_W-1:0])));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= SLOTS'(1) << (SLOTS-1);
      rb_q <= '0;
      av_q <= '0;
      ab_q <= '0;
    end else if (upd_en) begin
      rv_q <= rv_d;
      rb_q <= rb_d;
      av_q <= av_d;
      ab_q <= ab_d;
    end
  end

  assign rom_valid = rv_q;
  assign rom_bank  = rb_q;
  assign ram_valid = av_q;
  assign ram_bank  = ab_q;

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_hit || ram_hit) |=> ($stable(rom_valid) && $stable(ram_valid)
                               && $stable(rom_bank) && $stable(ram_bank)));
endmodule

// File: rtl/sbm_xlate.sv
module sbm_xlate
  import sbm_pkg::*;
#(
  parameter int ROM_BANK_W = 6,
  parameter int RAM_BANK_W = 5,
  localparam int ROM_A_W   = ROM_BANK_W + ROM_OFF_W,
  localparam int RAM_A_W   = RAM_BANK_W + RAM_OFF_W
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [WIN_W:0]                    bus_addr,
  input  logic                              bus_re,
  input  logic                              bus_we,
  input  logic [SLOTS-1:0]                  rom_valid,
  input  logic [SLOTS-1:0][ROM_BANK_W-1:0]  rom_bank,
  input  logic [SLOTS-1:0]                  ram_valid,
  input  logic [SLOTS-1:0][RAM_BANK_W-1:0]  ram_bank,
  input  logic [BYTE_W-1:0]                 rom_rdata,
  input  logic [BYTE_W-1:0]                 ram_rdata,
  output logic [ROM_A_W-1:0]                rom_addr,
  output logic                              rom_re,
  output logic [RAM_A_W-1:0]                ram_addr,
  output logic                              ram_re,
  output logic                              ram_we,
  output logic [BYTE_W-1:0]                 cart_rdata
);
  logic [WIN_W-1:0]  off;
  logic              in_win, ram_cover, rom_ok;
  logic [SLOT_W-1:0] ram_slot, rom_slot;

  always_comb begin
    in_win    = bus_addr[WIN_W];
    off       = bus_addr[WIN_W-1:0];
    ram_slot  = off[RAM_OFF_W +: SLOT_W];
    rom_slot  = off[ROM_OFF_W +: SLOT_W];
    ram_cover = in_win && ram_valid[ram_slot];
    rom_ok    = in_win && !ram_cover && rom_valid[rom_slot];
    ram_addr  = {ram_bank[ram_slot], off[RAM_OFF_W-1:0]};
    rom_addr  = {rom_bank[rom_slot], off[ROM_OFF_W-1:0]};
    ram_re    = bus_re && ram_cover && !off[WIN_W-1];
    ram_we    = bus_we && ram_cover &&  off[WIN_W-1];
    rom_re    = bus_re && rom_ok;
    if (ram_re)      cart_rdata = ram_rdata;
    else if (rom_re) cart_rdata = rom_rdata;
    else             cart_rdata = '1;
  end

  p_one_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_re && ram_re));
  p_we_alias_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (bus_addr[WIN_W] && bus_addr[WIN_W-1] && bus_we));
  p_read_low_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ram_re |-> (bus_addr[WIN_W] && !bus_addr[WIN_W-1]));
  p_idle_ff_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_re && !ram_re) |-> (cart_rdata == '1));
endmodule

// File: rtl/seg_bank_mapper.sv
module seg_bank_mapper
  import sbm_pkg::*;
#(
  parameter int ROM_BANK_W = 6,
  parameter int RAM_BANK_W = 5,
  localparam int ROM_A_W   = ROM_BANK_W + ROM_OFF_W,
  localparam int RAM_A_W   = RAM_BANK_W + RAM_OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [12:0]        bus_addr,
  input  logic               bus_re,
  input  logic               bus_we,
  input  logic [7:0]         bus_wdata,
  input  logic [7:0]         rom_rdata,
  input  logic [7:0]         ram_rdata,
  output logic [ROM_A_W-1:0] rom_addr,
  output logic               rom_re,
  output logic [RAM_A_W-1:0] ram_addr,
  output logic               ram_re,
  output logic               ram_we,
  output logic [7:0]         cart_rdata
);
  logic                             rom_hit, ram_hit;
  logic [SLOTS-1:0]                 rom_valid, ram_valid;
  logic [SLOTS-1:0][ROM_BANK_W-1:0] rom_bank;
  logic [SLOTS-1:0][RAM_BANK_W-1:0] ram_bank;

  sbm_hotspot u_hs (
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .rom_hit  (rom_hit),
    .ram_hit  (ram_hit)
  );

  sbm_map_regs #(.ROM_BANK_W(ROM_BANK_W), .RAM_BANK_W(RAM_BANK_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .rom_hit   (rom_hit),
    .ram_hit   (ram_hit),
    .wdata     (bus_wdata),
    .rom_valid (rom_valid),
    .rom_bank  (rom_bank),
    .ram_valid (ram_valid),
    .ram_bank  (ram_bank)
  );

  sbm_xlate #(.ROM_BANK_W(ROM_BANK_W), .RAM_BANK_W(RAM_BANK_W)) u_xl (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_re     (bus_re),
    .bus_we     (bus_we),
    .rom_valid  (rom_valid),
    .rom_bank   (rom_bank),
    .ram_valid  (ram_valid),
    .ram_bank   (ram_bank),
    .rom_rdata  (rom_rdata),
    .ram_rdata  (ram_rdata),
    .rom_addr   (rom_addr),
    .rom_re     (rom_re),
    .ram_addr   (ram_addr),
    .ram_re     (ram_re),
    .ram_we     (ram_we),
    .cart_rdata (cart_rdata)
  );

  p_hit_low_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_hit || ram_hit) |-> (!bus_addr[12] && bus_we && bus_addr[11:6] == 6'd0));
endmodule

// File: tb/seg_bank_mapper_test.sv
module seg_bank_mapper_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [12:0] bus_addr;
  logic        bus_re, bus_we;
  logic [7:0]  bus_wdata, rom_rdata, ram_rdata, cart_rdata;
  logic [15:0] rom_addr;
  logic [13:0] ram_addr;
  logic        rom_re, ram_re, ram_we;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit rm_v[4];
  int rm_b[4];
  bit am_v[4];
  int am_b[4];

  always #4 clk = ~clk;

  seg_bank_mapper uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_re(bus_re),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .rom_rdata(rom_rdata),
    .ram_rdata(ram_rdata), .rom_addr(rom_addr), .rom_re(rom_re),
    .ram_addr(ram_addr), .ram_re(ram_re), .ram_we(ram_we),
    .cart_rdata(cart_rdata)
  );

  function automatic logic [7:0] rom_fn(int a);
    return 8'((a + (a >> 8) * 7) & 255);
  endfunction
  function automatic logic [7:0] ram_fn(int a);
    return 8'(((a >> 3) ^ a ^ 8'h5A) & 255);
  endfunction

  always_comb rom_rdata = rom_fn(int'(rom_addr));
  always_comb ram_rdata = ram_fn(int'(ram_addr));

  task automatic hotspot(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d; bus_re = 1'b0;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = '0;
    if (a == 13'h003F) begin rm_v[d[7:6]] = 1; rm_b[d[7:6]] = int'(d[5:0]); end
    if (a == 13'h003E) begin am_v[d[7:6]] = 1; am_b[d[7:6]] = int'(d[5:0]) % 32; end
  endtask

  task automatic read_sweep(input string tag);
    for (int o = 0; o < 4096; o++) begin
      bit e_rom, e_ram; int e_addr; logic [7:0] e_d; string rq;
      e_rom = 0; e_ram = 0; e_addr = 0; e_d = 8'hFF; rq = "R8";
      if (o < 2048 && am_v[o / 512]) begin
        e_ram = 1; e_addr = am_b[o / 512] * 512 + o % 512; e_d = ram_fn(e_addr); rq = "R5";
      end else if (o >= 2048 && am_v[(o - 2048) / 512]) begin
        rq = "R7";
      end else if (rm_v[o / 1024]) begin
        e_rom = 1; e_addr = rm_b[o / 1024] * 1024 + o % 1024; e_d = rom_fn(e_addr); rq = "R9";
      end
      bus_we = 1'b0; bus_re = 1'b1; bus_addr = 13'h1000 | 13'(o);
      #1;
      checks++;
      if (rom_re !== e_rom || ram_re !== e_ram || cart_rdata !== e_d ||
          (e_rom && int'(rom_addr) != e_addr) || (e_ram && int'(ram_addr) != e_addr)) begin
        errors++;
        $display("FAIL %s %s off=%h act re=%b/%b d=%h ra=%h wa=%h exp re=%b/%b d=%h a=%h",
                 rq, tag, o, rom_re, ram_re, cart_rdata, rom_addr, ram_addr,
                 e_rom, e_ram, e_d, e_addr);
      end
    end
    bus_re = 1'b0;
  endtask

  task automatic write_sweep(input string tag);
    for (int o = 0; o < 4096; o++) begin
      bit e_we; int e_addr;
      e_we = (o >= 2048) && am_v[(o - 2048) / 512];
      e_addr = e_we ? am_b[(o - 2048) / 512] * 512 + o % 512 : 0;
      bus_re = 1'b0; bus_we = 1'b1; bus_wdata = 8'h00; bus_addr = 13'h1000 | 13'(o);
      #1;
      checks++;
      if (ram_we !== e_we || rom_re !== 1'b0 || (e_we && int'(ram_addr) != e_addr)) begin
        errors++;
        $display("FAIL R6 %s off=%h act we=%b a=%h exp we=%b a=%h",
                 tag, o, ram_we, ram_addr, e_we, e_addr);
      end
    end
    bus_we = 1'b0;
  endtask

  initial begin
    #1600000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin rm_v[i] = 0; rm_b[i] = 0; am_v[i] = 0; am_b[i] = 0; end
    rm_v[3] = 1;
    rst_n = 1'b0; bus_addr = '0; bus_re = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset mapping
    read_sweep("R1 reset");
    write_sweep("reset");
    // R2: ROM slot loads, seen in the next cycle
    hotspot(13'h003F, 8'h05);
    hotspot(13'h003F, 8'h6A);
    hotspot(13'h003F, 8'hBF);
    hotspot(13'h003F, 8'hC1);
    read_sweep("R2 rom");
    // R4: near-miss addresses change nothing
    hotspot(13'h103F, 8'h00);
    hotspot(13'h007F, 8'h00);
    hotspot(13'h003D, 8'h40);
    hotspot(13'h00BF, 8'h80);
    hotspot(13'h103E, 8'hC0);
    read_sweep("R4 nearmiss");
    // R3: RAM slots with modulo; R7 overlap with ROM
    hotspot(13'h003E, 8'h23);
    hotspot(13'h003E, 8'h41);
    read_sweep("R3 ram2");
    write_sweep("R3 ram2");
    // contiguous RAM in all four slots
    hotspot(13'h003E, 8'hBA);
    hotspot(13'h003E, 8'hDF);
    read_sweep("R7 ram4");
    write_sweep("R6 ram4");
    // remap a ROM slot underneath RAM
    hotspot(13'h003F, 8'h3E);
    read_sweep("R2 remap");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule